// File: doc/BRIEF.md
# Test Vector Bus Controller

This block lets an external tester drive an on-chip system bus through a narrow test port. The tester announces the kind of the next vector one cycle ahead on two request lines. It then presents that vector on a 32-bit test data bus. The controller turns each vector into a single-phase master transfer on the internal bus. An address vector loads the transfer address. A control vector sets the transfer size and whether the address steps. A write vector issues a write, and a read vector issues a read and returns the data to the tester.

Consecutive data vectors form a burst. The first transfer of a burst is non-sequential. Later ones are sequential and step the address, unless stepping is off, in which case every transfer goes non-sequentially to the same address. A burst may change direction at any vector. A read must be closed by a turnaround vector before the block leaves test mode. Raising the request lines while the block is idle enters test mode. An all-low code after anything other than a read leaves it.

Top module: `tvec_bridge`

## Requirements
- R1: After reset: `tack`=0, `test_mode`=0, `vec_err`=0, `tbus_oe`=0, `m_trans`=00, `m_addr`=0, `m_size` is the full bus width code (2 for a 32-bit bus), and address stepping is on.
- R2: The request code is {`treq_a`,`treq_b`} and names the vector of the following cycle: 11 address (or control), 01 write, 10 read, 00 turnaround/exit. Code 11 seen while out of test mode enters test mode. `tack` is 1 in every test-mode cycle that accepts a vector, and 0 out of test mode.
- R3: In an address-vector cycle, `m_addr` equals `tbus_in[ADDR_W-1:0]` in that same cycle, `m_trans` is 00, and that value becomes the burst address.
- R4: Code 11 given during an address-vector cycle makes the next cycle a control vector. Its word carries the size in bits [2:0] and the step enable in bit 4. A size no larger than log2(bus bytes) is valid, and the new size shows on `m_size` from the next cycle.
- R5: A control vector with an out-of-range size changes neither size nor stepping, and the next data vector is issued sequential (11) at the burst address.
- R6: `m_trans` encodes 00 idle, 10 non-sequential, 11 sequential. With stepping on, the first data vector after an address or valid control vector is 10 at the burst address. Each later one is 11 at the previous address plus 2^size, wrapping modulo 2^ADDR_W.
- R7: With stepping off, every data vector is issued as 10 at the unchanged burst address.
- R8: A write vector drives `m_write`=1 and `m_wdata`=`tbus_in`.
- R9: While a data vector meets `m_wait`=1, `tack` is 0, the transfer and its address are held, and the request code is ignored.
- R10: A read vector drives `m_write`=0, `tbus_oe`=1 and `tbus_out`=`m_rdata` in the same cycle. `tbus_oe` is 0 in all other cycles.
- R11: A burst may switch between read and write vectors, and stepping and sequential issue carry on across the switch.
- R12: Code 00 after a read vector yields a turnaround cycle: still in test mode, no transfer, `tbus_oe`=0. Code 00 after any other vector leaves test mode.
- R13: A write or read vector announced before any address vector of the session issues no transfer and sets `vec_err`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| treq_a | input | 1 | Request line, upper code bit |
| treq_b | input | 1 | Request line, lower code bit |
| tack | output | 1 | Vector accepted |
| tbus_in | input | TBUS_W | Test bus value from the tester |
| tbus_out | output | TBUS_W | Read data toward the tester |
| tbus_oe | output | 1 | Enable for the test bus pad driver |
| test_mode | output | 1 | Block is in test mode |
| vec_err | output | 1 | Sticky: data vector seen before an address |
| m_addr | output | ADDR_W | Internal bus address |
| m_trans | output | 2 | Internal transfer type |
| m_size | output | 3 | Internal transfer size, log2 bytes |
| m_write | output | 1 | Internal write flag |
| m_wdata | output | TBUS_W | Internal write data |
| m_rdata | input | TBUS_W | Internal read data |
| m_wait | input | 1 | Internal slave wait |

## Verification
The bench keeps the 32-bit test bus but narrows the address to ADDR_W=16. A burst started near the top of the address space then wraps to zero within two transfers, so the modulo behaviour of the stepping adder is observed directly. The default size of 2 keeps the four-step write burst comparable with word addressing. A later session sets size 1 to show a 2-byte stride.

// File: rtl/tvec_pkg.sv
package tvec_pkg;

  typedef enum logic [2:0] {
    VK_OFF   = 3'd0,
    VK_IDLE  = 3'd1,
    VK_ADDR  = 3'd2,
    VK_CTRL  = 3'd3,
    VK_WRITE = 3'd4,
    VK_READ  = 3'd5,
    VK_TURN  = 3'd6
  } vkind_t;

  localparam logic [1:0] RQ_NONE = 2'b00;
  localparam logic [1:0] RQ_WR   = 2'b01;
  localparam logic [1:0] RQ_RD   = 2'b10;
  localparam logic [1:0] RQ_ADDR = 2'b11;

  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_NSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ  = 2'b11;

  localparam int SIZE_W     = 3;
  localparam int CW_SIZE_LSB = 0;
  localparam int CW_INC_BIT = 4;

  function automatic logic is_data(vkind_t k);
    return (k == VK_WRITE) || (k == VK_READ);
  endfunction

endpackage

// File: rtl/tvec_rst_sync.sv
module tvec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tvec_seq.sv
module tvec_seq
  import tvec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rq,
  input  logic       m_wait,
  output vkind_t     kind,
  output logic       advance,
  output logic       err
);
  vkind_t kind_q, kind_nx;
  logic   have_q, have_nx, have_now;
  logic   err_q, err_set;

  always_comb begin
    advance  = !(is_data(kind_q) && m_wait);
    have_now = have_q || (kind_q == VK_ADDR);
    kind_nx  = kind_q;
    err_set  = 1'b0;
    if (kind_q == VK_OFF) begin
      case (rq)
        RQ_ADDR: kind_nx = VK_ADDR;
        RQ_WR, RQ_RD: begin
          kind_nx = VK_IDLE;
          err_set = 1'b1;
        end
        default: kind_nx = VK_OFF;
      endcase
    end else begin
      case (rq)
        RQ_ADDR: kind_nx = (kind_q == VK_ADDR) ? VK_CTRL : VK_ADDR;
        RQ_WR: begin
          if (have_now) kind_nx = VK_WRITE;
          else begin
            kind_nx = VK_IDLE;
            err_set = 1'b1;
          end
        end
        RQ_RD: begin
          if (have_now) kind_nx = VK_READ;
          else begin
            kind_nx = VK_IDLE;
            err_set = 1'b1;
          end
        end
        default: kind_nx = (kind_q == VK_READ) ? VK_TURN : VK_OFF;
      endcase
    end
    have_nx = (kind_nx == VK_OFF) ? 1'b0 : have_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= VK_OFF;
      have_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (advance) begin
      kind_q <= kind_nx;
      have_q <= have_nx;
      if (err_set) err_q <= 1'b1;
    end
  end

  assign kind = kind_q;
  assign err  = err_q;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_data(kind_q) && m_wait) |=> (kind_q == $past(kind_q)));

  // R12
  read_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == VK_READ && rq == RQ_NONE && !m_wait) |=> (kind_q == VK_TURN));

  // R13
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/tvec_ctx.sv
module tvec_ctx
  import tvec_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_SIZE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  vkind_t            kind,
  input  logic              m_wait,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [SIZE_W-1:0] ctl_size,
  input  logic              ctl_inc,
  output logic [ADDR_W-1:0] addr,
  output logic [SIZE_W-1:0] size,
  output logic              inc,
  output logic              fresh
);
  logic [ADDR_W-1:0] addr_q, addr_nx, stride;
  logic [SIZE_W-1:0] size_q, size_nx;
  logic              inc_q, inc_nx, fresh_q, fresh_nx;
  logic              xfer_done, ctl_ok, load;

  always_comb begin
    xfer_done = is_data(kind) && !m_wait;
    ctl_ok    = (ctl_size <= SIZE_W'(MAX_SIZE));
    stride    = {{(ADDR_W-1){1'b0}}, 1'b1} << size_q;
    addr_nx   = addr_q;
    size_nx   = size_q;
    inc_nx    = inc_q;
    fresh_nx  = fresh_q;
    load      = 1'b0;
    case (kind)
      VK_ADDR: begin
        load     = 1'b1;
        addr_nx  = addr_in;
        fresh_nx = 1'b1;
      end
      VK_CTRL: begin
        load = 1'b1;
        if (ctl_ok) begin
          size_nx  = ctl_size;
          inc_nx   = ctl_inc;
          fresh_nx = 1'b1;
        end else begin
          fresh_nx = 1'b0;
        end
      end
      default: begin
        if (xfer_done) begin
          load     = 1'b1;
          fresh_nx = 1'b0;
          if (inc_q) addr_nx = addr_q + stride;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      size_q  <= SIZE_W'(MAX_SIZE);
      inc_q   <= 1'b1;
      fresh_q <= 1'b0;
    end else if (load) begin
      addr_q  <= addr_nx;
      size_q  <= size_nx;
      inc_q   <= inc_nx;
      fresh_q <= fresh_nx;
    end
  end

  assign addr  = addr_q;
  assign size  = size_q;
  assign inc   = inc_q;
  assign fresh = fresh_q;

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_data(kind) && m_wait) |=> $stable(addr_q));

  // R7
  noinc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_data(kind) && !inc_q && !m_wait) |=> $stable(addr_q));
endmodule

// File: rtl/tvec_drive.sv
module tvec_drive
  import tvec_pkg::*;
#(
  parameter int TBUS_W = 32,
  parameter int ADDR_W = 32
) (
  input  vkind_t            kind,
  input  logic              advance,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              inc_q,
  input  logic              fresh_q,
  input  logic [TBUS_W-1:0] bus_in,
  input  logic [TBUS_W-1:0] rdata,
  output logic              tack,
  output logic              test_mode,
  output logic [ADDR_W-1:0] m_addr,
  output logic [1:0]        m_trans,
  output logic              m_write,
  output logic [TBUS_W-1:0] m_wdata,
  output logic [TBUS_W-1:0] tbus_out,
  output logic              tbus_oe
);
  always_comb begin
    test_mode = (kind != VK_OFF);
    tack      = test_mode && advance;
    m_addr    = (kind == VK_ADDR) ? addr_in : addr_q;
    if (is_data(kind)) m_trans = (fresh_q || !inc_q) ? TR_NSEQ : TR_SEQ;
    else               m_trans = TR_IDLE;
    m_write   = (kind == VK_WRITE);
    m_wdata   = bus_in;
    tbus_oe   = (kind == VK_READ);
    tbus_out  = rdata;
  end
endmodule

// File: rtl/tvec_bridge.sv
module tvec_bridge
  import tvec_pkg::*;
#(
  parameter int TBUS_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              treq_a,
  input  logic              treq_b,
  output logic              tack,
  input  logic [TBUS_W-1:0] tbus_in,
  output logic [TBUS_W-1:0] tbus_out,
  output logic              tbus_oe,
  output logic              test_mode,
  output logic              vec_err,
  output logic [ADDR_W-1:0] m_addr,
  output logic [1:0]        m_trans,
  output logic [2:0]        m_size,
  output logic              m_write,
  output logic [TBUS_W-1:0] m_wdata,
  input  logic [TBUS_W-1:0] m_rdata,
  input  logic              m_wait
);
  localparam int MAX_SIZE = $clog2(TBUS_W / 8);

  logic              rst_ni;
  vkind_t            kind;
  logic              advance;
  logic [ADDR_W-1:0] addr_q;
  logic [SIZE_W-1:0] size_q;
  logic              inc_q, fresh_q;

  tvec_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni)
  );

  tvec_seq u_seq (
    .clk(clk), .rst_n(rst_ni), .rq({treq_a, treq_b}), .m_wait(m_wait),
    .kind(kind), .advance(advance), .err(vec_err)
  );

  tvec_ctx #(.ADDR_W(ADDR_W), .MAX_SIZE(MAX_SIZE)) u_ctx (
    .clk(clk), .rst_n(rst_ni), .kind(kind), .m_wait(m_wait),
    .addr_in(tbus_in[ADDR_W-1:0]),
    .ctl_size(tbus_in[CW_SIZE_LSB +: SIZE_W]),
    .ctl_inc(tbus_in[CW_INC_BIT]),
    .addr(addr_q), .size(size_q), .inc(inc_q), .fresh(fresh_q)
  );

  tvec_drive #(.TBUS_W(TBUS_W), .ADDR_W(ADDR_W)) u_drv (
    .kind(kind), .advance(advance), .addr_q(addr_q),
    .addr_in(tbus_in[ADDR_W-1:0]), .inc_q(inc_q), .fresh_q(fresh_q),
    .bus_in(tbus_in), .rdata(m_rdata),
    .tack(tack), .test_mode(test_mode), .m_addr(m_addr), .m_trans(m_trans),
    .m_write(m_write), .m_wdata(m_wdata), .tbus_out(tbus_out), .tbus_oe(tbus_oe)
  );

  assign m_size = size_q;

  // R2
  tack_mode_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    tack |-> test_mode);

  // R10
  oe_read_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    tbus_oe |-> (!m_write && m_trans != TR_IDLE));

  // R6
  trans_mode_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (m_trans != TR_IDLE) |-> test_mode);

  // R9
  wait_tack_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (m_trans != TR_IDLE && m_wait) |-> !tack);
endmodule

// File: tb/tvec_bridge_test.sv
`timescale 1ns/1ps
module tvec_bridge_test;
  localparam int TW = 32;
  localparam int AW = 16;
  localparam logic [1:0] C_OFF = 2'b00, C_WR = 2'b01, C_RD = 2'b10, C_AD = 2'b11;
  localparam logic [1:0] NS = 2'b10, SQ = 2'b11;

  logic clk = 1'b0;
  logic rst_n, treq_a, treq_b, m_wait;
  logic [TW-1:0] tbus_in, tbus_out, m_wdata, m_rdata;
  logic tack, tbus_oe, test_mode, vec_err, m_write;
  logic [AW-1:0] m_addr;
  logic [1:0] m_trans;
  logic [2:0] m_size;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [AW-1:0] a;
    logic [1:0]    t;
    logic          w;
    logic [TW-1:0] d;
    string         tag;
  } xp_t;
  xp_t sb[$];

  always #4 clk = ~clk;

  assign m_rdata = {16'hC3A5, m_addr};

  tvec_bridge #(.TBUS_W(TW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .treq_a(treq_a), .treq_b(treq_b), .tack(tack),
    .tbus_in(tbus_in), .tbus_out(tbus_out), .tbus_oe(tbus_oe),
    .test_mode(test_mode), .vec_err(vec_err), .m_addr(m_addr), .m_trans(m_trans),
    .m_size(m_size), .m_write(m_write), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .m_wait(m_wait)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && m_trans != 2'b00 && !m_wait) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R6 unexpected transfer", {16'h0, m_addr}, 32'h0);
      end else begin
        xp_t e;
        e = sb.pop_front();
        chk(m_addr == e.a, {e.tag, " address"}, {16'h0, m_addr}, {16'h0, e.a});
        chk(m_trans == e.t, {e.tag, " transfer type"}, {30'h0, m_trans}, {30'h0, e.t});
        chk(m_write == e.w, {e.tag, " R8/R10 direction"}, {31'h0, m_write}, {31'h0, e.w});
        if (e.w) chk(m_wdata == e.d, "R8 write data", m_wdata, e.d);
        else begin
          chk(tbus_oe == 1'b1, "R10 pad enable on read", {31'h0, tbus_oe}, 32'h1);
          chk(tbus_out == e.d, "R10 read data returned", tbus_out, e.d);
        end
      end
    end
  end

  task automatic step(input logic [1:0] c, input logic [TW-1:0] b, input logic w);
    @(posedge clk);
    #1;
    treq_a = c[1];
    treq_b = c[0];
    tbus_in = b;
    m_wait = w;
  endtask

  task automatic dvec(input bit wr, input logic [TW-1:0] d, input logic [1:0] nxt,
                      input logic [AW-1:0] ea, input logic [1:0] et, input int waits,
                      input string tag);
    xp_t e;
    e.a = ea; e.t = et; e.w = wr; e.d = wr ? d : {16'hC3A5, ea}; e.tag = tag;
    sb.push_back(e);
    for (int i = 0; i < waits; i++) begin
      step(nxt, d, 1'b1);
      @(negedge clk);
      chk(tack == 1'b0, "R9 tack low during wait", {31'h0, tack}, 32'h0);
      chk(m_addr == ea, "R9 address held during wait", {16'h0, m_addr}, {16'h0, ea});
    end
    step(nxt, d, 1'b0);
    @(negedge clk);
    chk(tack == 1'b1, "R2 tack accepts vector", {31'h0, tack}, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; treq_a = 1'b0; treq_b = 1'b0; tbus_in = '0; m_wait = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) step(C_OFF, 32'h0, 1'b0);
    @(negedge clk);
    // R1 reset state
    chk(tack == 0, "R1 tack", {31'h0, tack}, 0);
    chk(test_mode == 0, "R1 test_mode", {31'h0, test_mode}, 0);
    chk(vec_err == 0, "R1 vec_err", {31'h0, vec_err}, 0);
    chk(tbus_oe == 0, "R1 tbus_oe", {31'h0, tbus_oe}, 0);
    chk(m_trans == 0, "R1 m_trans", {30'h0, m_trans}, 0);
    chk(m_addr == 0, "R1 m_addr", {16'h0, m_addr}, 0);
    chk(m_size == 3'd2, "R1 m_size", {29'h0, m_size}, 2);

    // Session A: stepping burst, wait, direction changes, turnaround, exit
    step(C_AD, 32'h0, 1'b0);
    step(C_AD, 32'h0000_1000, 1'b0);
    @(negedge clk);
    chk(m_addr == 16'h1000, "R3 address passes through", {16'h0, m_addr}, 32'h1000);
    chk(m_trans == 2'b00, "R3 address vector idle", {30'h0, m_trans}, 0);
    chk(test_mode == 1, "R2 entry on code 11", {31'h0, test_mode}, 1);
    step(C_WR, 32'h0000_0012, 1'b0);
    dvec(1'b1, 32'h1111_0000, C_WR, 16'h1000, NS, 0, "R6 first write");
    dvec(1'b1, 32'h2222_0001, C_WR, 16'h1004, SQ, 0, "R6 seq write");
    dvec(1'b1, 32'h3333_0002, C_WR, 16'h1008, SQ, 2, "R9 waited write");
    dvec(1'b1, 32'h4444_0003, C_RD, 16'h100C, SQ, 0, "R6 seq write 4");
    dvec(1'b0, 32'h0,         C_RD, 16'h1010, SQ, 0, "R11 write to read");
    dvec(1'b0, 32'h0,         C_WR, 16'h1014, SQ, 1, "R10 waited read");
    dvec(1'b1, 32'h5555_0004, C_RD, 16'h1018, SQ, 0, "R11 read to write");
    dvec(1'b0, 32'h0,         C_OFF, 16'h101C, SQ, 0, "R11 write to read");
    step(C_OFF, 32'h0, 1'b0);
    @(negedge clk);
    chk(test_mode == 1, "R12 turnaround keeps test mode", {31'h0, test_mode}, 1);
    chk(tbus_oe == 0, "R12 turnaround releases bus", {31'h0, tbus_oe}, 0);
    chk(m_trans == 0, "R12 turnaround no transfer", {30'h0, m_trans}, 0);
    step(C_OFF, 32'h0, 1'b0);
    @(negedge clk);
    chk(test_mode == 0, "R12 exit after turnaround", {31'h0, test_mode}, 0);
    chk(tack == 0, "R2 tack low out of test mode", {31'h0, tack}, 0);

    // Session C: invalid control vector
    step(C_AD, 32'h0, 1'b0);
    step(C_AD, 32'h0000_3000, 1'b0);
    step(C_WR, 32'h0000_0017, 1'b0);
    dvec(1'b1, 32'h6666_0000, C_WR, 16'h3000, SQ, 0, "R5 seq after bad control");
    chk(m_size == 3'd2, "R5 size unchanged", {29'h0, m_size}, 2);
    dvec(1'b1, 32'h7777_0001, C_OFF, 16'h3004, SQ, 0, "R5 stepping kept");
    step(C_OFF, 32'h0, 1'b0);
    @(negedge clk);
    chk(test_mode == 0, "R12 exit after write", {31'h0, test_mode}, 0);

    // Session B: stepping disabled
    step(C_AD, 32'h0, 1'b0);
    step(C_AD, 32'h0000_2000, 1'b0);
    step(C_WR, 32'h0000_0002, 1'b0);
    dvec(1'b1, 32'h8888_0000, C_WR, 16'h2000, NS, 0, "R7 fixed address 1");
    dvec(1'b1, 32'h8888_0001, C_RD, 16'h2000, NS, 1, "R7 fixed address 2");
    dvec(1'b0, 32'h0,         C_OFF, 16'h2000, NS, 0, "R7 fixed address 3");
    step(C_OFF, 32'h0, 1'b0);
    step(C_OFF, 32'h0, 1'b0);

    // Session D: size 1 with address wrap
    step(C_AD, 32'h0, 1'b0);
    step(C_AD, 32'h0000_FFFE, 1'b0);
    step(C_RD, 32'h0000_0011, 1'b0);
    dvec(1'b0, 32'h0, C_RD, 16'hFFFE, NS, 0, "R6 halfword read");
    chk(m_size == 3'd1, "R4 new size visible", {29'h0, m_size}, 1);
    dvec(1'b0, 32'h0, C_OFF, 16'h0000, SQ, 0, "R6 address wraps");
    step(C_OFF, 32'h0, 1'b0);
    step(C_OFF, 32'h0, 1'b0);
    @(negedge clk);
    chk(vec_err == 0, "R13 no error yet", {31'h0, vec_err}, 0);

    // Session E: data vector before any address
    step(C_WR, 32'h0, 1'b0);
    step(C_OFF, 32'hDEAD_BEEF, 1'b0);
    @(negedge clk);
    chk(m_trans == 0, "R13 ignored vector no transfer", {30'h0, m_trans}, 0);
    chk(vec_err == 1, "R13 error flag set", {31'h0, vec_err}, 1);
    step(C_OFF, 32'h0, 1'b0);
    step(C_OFF, 32'h0, 1'b0);
    @(negedge clk);
    chk(vec_err == 1, "R13 error flag sticky", {31'h0, vec_err}, 1);
    chk(sb.size() == 0, "R6 all expected transfers issued", sb.size(), 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule